// File: doc/BRIEF.md
# Configurable Filter Tuple Packer

This block packs up to ten packet classification fields into one compact match tuple for a downstream filter lookup. A programmable mode mask chooses which fields take part. Each enabled field is placed directly above the enabled fields with lower mask bits, so the tuple has no gaps. Field positions therefore change at runtime and are not fixed. A separate configuration bit decides whether the virtual-NIC slot carries a function identifier or an outer VLAN tag. In the second case the slot is still packed, but its offset is reported as not usable.

Software loads the mask and the slot-mode bit with a one-cycle strobe. A small controller with four states handles the configuration:
- `CS_EMPTY`: the state after reset, and the state after a load of an all-zero mask.
- `CS_SETTLE`: the single cycle in which offsets are recomputed from the captured mask.
- `CS_READY`: a valid, non-empty configuration is in use.
- `CS_FAULT`: the enabled widths add up to more than the tuple can hold.

Any load moves the controller to `CS_SETTLE`, and a load during `CS_SETTLE` keeps it there. When `CS_SETTLE` ends, the controller moves to `CS_FAULT` if the total width is too large, to `CS_EMPTY` if the mask is zero, and to `CS_READY` otherwise. Field values arrive on one flat bus with an input valid strobe. The packed tuple leaves one cycle later with its own valid strobe. A per-field present flag and offset are reported continuously.

Top module: `tuple_packer`

## Requirements
- R1: The fields use mask bits 0 to 9, with these widths in bits: 1, 3, 17, 17, 8, 8, 16, 9, 3 and 1. On `fld_i`, field k sits at the sum of the widths of fields 0 to k-1 (bases 0, 1, 4, 21, 38, 46, 54, 70, 79 and 82). The offset of an enabled field is the sum of the widths of the enabled fields with lower mask bits. Offsets are 8-bit two's complement values, and field k's offset is on `offset_o[8k+7:8k]`.
- R2: A field whose mask bit is clear has `present_o[k]=0` and offset 8'hFF (-1), and it occupies no tuple bits.
- R3: With `cfg_vnic_i=0` at load, field 2 still counts as present, is packed and shifts the fields above it, but its reported offset is -1.
- R4: Enabled field values are packed contiguously from tuple bit 0 upward. All tuple bits at or above the total enabled width are zero.
- R5: `out_valid_o` is high in exactly the cycle after the one in which `in_valid_i` was sampled high while the configuration is in use. `tuple_o` is registered at that same edge.
- R6: A load captures the mask and mode at clock edge e0. Present flags and offsets change at the next edge e1. An `in_valid_i` sampled at e1 produces no output.
- R7: If the enabled widths add up to more than TUPLE_MAX (default 36), `cfg_err_o` is 1 from e1 onward, and `in_valid_i` produces no `out_valid_o`.
- R8: A configuration whose total equals exactly TUPLE_MAX is accepted, and its top field reaches bit TUPLE_MAX-1.
- R9: After reset, every field is absent with offset -1, `cfg_err_o` and `out_valid_o` are 0, and an input produces a valid tuple of zero.
- R10: A later load of a legal configuration clears `cfg_err_o` and restores output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_load_i | input | 1 | Capture strobe for mask and slot mode |
| cfg_mask_i | input | 10 | Field enable mask, bit k enables field k |
| cfg_vnic_i | input | 1 | 1: slot 2 holds a function identifier; 0: slot 2 holds an outer VLAN |
| in_valid_i | input | 1 | Field bus is valid |
| fld_i | input | 83 | All ten field values at fixed bases |
| out_valid_o | output | 1 | Tuple valid |
| tuple_o | output | TUPLE_MAX | Packed tuple |
| present_o | output | 10 | Per-field present flag |
| offset_o | output | 80 | Per-field signed offset, 8 bits each |
| cfg_err_o | output | 1 | Configuration exceeds tuple width |

## Verification
The assertions expect `cfg_load_i` and `in_valid_i` to be low from reset until the bench first drives them. They also expect the mask and mode to reach the block only through the load strobe. The upper-zero check assumes that the internal total stays constant while a valid output is shown. This holds because the total changes only in the settle cycle, and that cycle never produces output. The stimulus changes its inputs only on falling edges, pulses each strobe for exactly one cycle, and keeps field values within their stated widths.

// File: rtl/tpk_pkg.sv
package tpk_pkg;

    localparam int NUM_FLD = 10;
    localparam int VNIC_IDX = 2;
    localparam int VLAN_IDX = 3;

    // Sub-field layout inside the tag slots, relative to each slot base
    localparam int TAG_VLD_BIT = 16;
    localparam int VF_LSB = 0;
    localparam int VF_W = 7;
    localparam int PF_LSB = 7;
    localparam int PF_W = 3;

    function automatic int fld_width(input int k);
        case (k)
            0: return 1;
            1: return 3;
            2: return 17;
            3: return 17;
            4: return 8;
            5: return 8;
            6: return 16;
            7: return 9;
            8: return 3;
            9: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic int fld_base(input int k);
        int s;
        s = 0;
        for (int j = 0; j < k; j++) s += fld_width(j);
        return s;
    endfunction

    localparam int FLD_BUS_W = fld_base(NUM_FLD);
    localparam int OFF_W = $clog2(FLD_BUS_W + 1) + 1;

    typedef enum logic [1:0] {
        CS_EMPTY  = 2'd0,
        CS_SETTLE = 2'd1,
        CS_READY  = 2'd2,
        CS_FAULT  = 2'd3
    } cfg_state_e;

endpackage

// File: rtl/tpk_offset_calc.sv
module tpk_offset_calc
    import tpk_pkg::*;
(
    input  logic [NUM_FLD-1:0]       mask_i,
    output logic [NUM_FLD*OFF_W-1:0] raw_off_o,
    output logic [OFF_W-1:0]         total_o
);

    // Running sum: each field's base is the width of enabled fields below it
    always_comb begin
        logic [OFF_W-1:0] acc;
        acc = '0;
        raw_off_o = '0;
        for (int k = 0; k < NUM_FLD; k++) begin
            raw_off_o[k*OFF_W +: OFF_W] = acc;
            if (mask_i[k]) acc = acc + OFF_W'(fld_width(k));
        end
        total_o = acc;
    end

endmodule

// File: rtl/tpk_cfg_ctrl.sv
module tpk_cfg_ctrl
    import tpk_pkg::*;
#(
    parameter int TUPLE_MAX = 36
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     load_i,
    input  logic [NUM_FLD-1:0]       mask_i,
    input  logic                     vnic_i,
    output logic                     pass_en_o,
    output logic                     cfg_err_o,
    output logic [NUM_FLD-1:0]       present_o,
    output logic [NUM_FLD*OFF_W-1:0] raw_off_o,
    output logic [NUM_FLD*OFF_W-1:0] rep_off_o,
    output logic [OFF_W-1:0]         total_o
);

    cfg_state_e state_q, state_d;
    logic [NUM_FLD-1:0]       mask_q;
    logic                     vnic_q;
    logic [NUM_FLD*OFF_W-1:0] calc_off;
    logic [OFF_W-1:0]         calc_total;
    logic                     too_wide;

    tpk_offset_calc calc_i (
        .mask_i    (mask_q),
        .raw_off_o (calc_off),
        .total_o   (calc_total)
    );

    assign too_wide = int'(calc_total) > TUPLE_MAX;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= CS_EMPTY;
        else         state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        pass_en_o = 1'b0;
        cfg_err_o = 1'b0;
        unique case (state_q)
            CS_EMPTY: begin
                pass_en_o = 1'b1;
                if (load_i) state_d = CS_SETTLE;
            end
            CS_READY: begin
                pass_en_o = 1'b1;
                if (load_i) state_d = CS_SETTLE;
            end
            CS_FAULT: begin
                cfg_err_o = 1'b1;
                if (load_i) state_d = CS_SETTLE;
            end
            CS_SETTLE: begin
                if (load_i)              state_d = CS_SETTLE;
                else if (too_wide)       state_d = CS_FAULT;
                else if (mask_q == '0)   state_d = CS_EMPTY;
                else                     state_d = CS_READY;
            end
            default: state_d = CS_EMPTY;
        endcase
    end

    // Configuration capture on the load strobe
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mask_q <= '0;
            vnic_q <= 1'b0;
        end else if (load_i) begin
            mask_q <= mask_i;
            vnic_q <= vnic_i;
        end
    end

    // Offset commit during the settle cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            present_o <= '0;
            raw_off_o <= '0;
            rep_off_o <= '1;
            total_o   <= '0;
        end else if (state_q == CS_SETTLE) begin
            present_o <= mask_q;
            raw_off_o <= calc_off;
            total_o   <= calc_total;
            for (int k = 0; k < NUM_FLD; k++) begin
                if (!mask_q[k] || (k == VNIC_IDX && !vnic_q))
                    rep_off_o[k*OFF_W +: OFF_W] <= '1;
                else
                    rep_off_o[k*OFF_W +: OFF_W] <= calc_off[k*OFF_W +: OFF_W];
            end
        end
    end

endmodule

// File: rtl/tpk_pack_stage.sv
module tpk_pack_stage
    import tpk_pkg::*;
#(
    parameter int TUPLE_MAX = 36
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     in_valid_i,
    input  logic                     pass_en_i,
    input  logic [NUM_FLD-1:0]       present_i,
    input  logic [NUM_FLD*OFF_W-1:0] raw_off_i,
    input  logic [FLD_BUS_W-1:0]     fld_i,
    output logic                     out_valid_o,
    output logic [TUPLE_MAX-1:0]     tuple_o
);

    logic [TUPLE_MAX-1:0] ext [NUM_FLD];
    logic [TUPLE_MAX-1:0] packed_w;

    for (genvar g = 0; g < NUM_FLD; g++) begin : gen_ext
        localparam int B = fld_base(g);
        localparam int W = fld_width(g);
        if (W < TUPLE_MAX) begin : gen_pad
            assign ext[g] = {{(TUPLE_MAX-W){1'b0}}, fld_i[B +: W]};
        end else begin : gen_cut
            assign ext[g] = fld_i[B +: TUPLE_MAX];
        end
    end

    always_comb begin
        packed_w = '0;
        for (int k = 0; k < NUM_FLD; k++) begin
            if (present_i[k])
                packed_w = packed_w | (ext[k] << raw_off_i[k*OFF_W +: OFF_W]);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_valid_o <= 1'b0;
            tuple_o     <= '0;
        end else begin
            out_valid_o <= in_valid_i && pass_en_i;
            if (in_valid_i && pass_en_i) tuple_o <= packed_w;
        end
    end

endmodule

// File: rtl/tuple_packer.sv
module tuple_packer
    import tpk_pkg::*;
#(
    parameter int TUPLE_MAX = 36
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     cfg_load_i,
    input  logic [NUM_FLD-1:0]       cfg_mask_i,
    input  logic                     cfg_vnic_i,
    input  logic                     in_valid_i,
    input  logic [FLD_BUS_W-1:0]     fld_i,
    output logic                     out_valid_o,
    output logic [TUPLE_MAX-1:0]     tuple_o,
    output logic [NUM_FLD-1:0]       present_o,
    output logic [NUM_FLD*OFF_W-1:0] offset_o,
    output logic                     cfg_err_o
);

    logic                     pass_en;
    logic [NUM_FLD*OFF_W-1:0] raw_off;
    logic [OFF_W-1:0]         total_w;

    tpk_cfg_ctrl #(.TUPLE_MAX(TUPLE_MAX)) ctrl_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (cfg_load_i),
        .mask_i    (cfg_mask_i),
        .vnic_i    (cfg_vnic_i),
        .pass_en_o (pass_en),
        .cfg_err_o (cfg_err_o),
        .present_o (present_o),
        .raw_off_o (raw_off),
        .rep_off_o (offset_o),
        .total_o   (total_w)
    );

    tpk_pack_stage #(.TUPLE_MAX(TUPLE_MAX)) pack_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .in_valid_i  (in_valid_i),
        .pass_en_i   (pass_en),
        .present_i   (present_o),
        .raw_off_i   (raw_off),
        .fld_i       (fld_i),
        .out_valid_o (out_valid_o),
        .tuple_o     (tuple_o)
    );

endmodule

// File: rtl/tpk_checker.sv
module tpk_checker
    import tpk_pkg::*;
#(
    parameter int TUPLE_MAX = 36
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic                     cfg_load_i,
    input logic                     in_valid_i,
    input logic                     out_valid_o,
    input logic                     cfg_err_o,
    input logic [TUPLE_MAX-1:0]     tuple_o,
    input logic [NUM_FLD-1:0]       present_o,
    input logic [NUM_FLD*OFF_W-1:0] offset_o,
    input logic [OFF_W-1:0]         total_i
);

    assert_valid_follows_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o |-> $past(in_valid_i));

    assert_settle_blocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_load_i |-> ##2 !out_valid_o);

    assert_fault_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_err_o |-> !out_valid_o);

    assert_upper_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o |-> ((tuple_o >> total_i) == '0));

    for (genvar g = 0; g < NUM_FLD; g++) begin : gen_abs
        assert_absent_offset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !present_o[g] |-> (offset_o[g*OFF_W +: OFF_W] == '1));
    end

endmodule

bind tuple_packer tpk_checker #(.TUPLE_MAX(TUPLE_MAX)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_load_i  (cfg_load_i),
    .in_valid_i  (in_valid_i),
    .out_valid_o (out_valid_o),
    .cfg_err_o   (cfg_err_o),
    .tuple_o     (tuple_o),
    .present_o   (present_o),
    .offset_o    (offset_o),
    .total_i     (total_w)
);

// File: tb/tuple_packer_tb_top.sv
module tuple_packer_tb_top;

    localparam int TMAX = 36;
    localparam int NF = 10;
    localparam int BUSW = 83;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_load = 1'b0;
    logic [NF-1:0] cfg_mask = '0;
    logic cfg_vnic = 1'b0;
    logic in_valid = 1'b0;
    logic [BUSW-1:0] fld = '0;
    logic out_valid;
    logic [TMAX-1:0] tuple;
    logic [NF-1:0] present;
    logic [NF*8-1:0] offset;
    logic cfg_err;

    int n_checks = 0;
    int n_errs = 0;
    int widths [NF] = '{1, 3, 17, 17, 8, 8, 16, 9, 3, 1};
    logic [16:0] pat_a [NF] = '{17'h1, 17'h5, 17'h1ABCD, 17'h10FFF, 17'hA5,
                                17'h06, 17'h88F7, 17'h155, 17'h6, 17'h1};
    logic [16:0] pat_one [NF];

    always #2 clk = ~clk;

    tuple_packer #(.TUPLE_MAX(TMAX)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cfg_load_i(cfg_load), .cfg_mask_i(cfg_mask),
        .cfg_vnic_i(cfg_vnic), .in_valid_i(in_valid), .fld_i(fld),
        .out_valid_o(out_valid), .tuple_o(tuple), .present_o(present),
        .offset_o(offset), .cfg_err_o(cfg_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [BUSW-1:0] mk_bus(input logic [16:0] v [NF]);
        logic [BUSW-1:0] b;
        int pos;
        b = '0;
        pos = 0;
        for (int k = 0; k < NF; k++) begin
            for (int i = 0; i < widths[k]; i++) b[pos+i] = v[k][i];
            pos += widths[k];
        end
        return b;
    endfunction

    function automatic logic [127:0] exp_tuple(input logic [NF-1:0] m, input logic [16:0] v [NF]);
        logic [127:0] t;
        int pos;
        t = '0;
        pos = 0;
        for (int k = 0; k < NF; k++) begin
            if (m[k]) begin
                for (int i = 0; i < widths[k]; i++) t[pos+i] = v[k][i];
                pos += widths[k];
            end
        end
        return t;
    endfunction

    function automatic logic [7:0] exp_off(input logic [NF-1:0] m, input logic vn, input int k);
        int pos;
        pos = 0;
        if (!m[k] || (k == 2 && !vn)) return 8'hFF;
        for (int j = 0; j < k; j++) if (m[j]) pos += widths[j];
        return 8'(pos);
    endfunction

    task automatic load_cfg(input logic [NF-1:0] m, input logic vn);
        cfg_load = 1'b1;
        cfg_mask = m;
        cfg_vnic = vn;
        @(negedge clk);
        cfg_load = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_cfg(input logic [NF-1:0] m, input logic vn, input string req);
        chk(present == m, req, "present", 128'(present), 128'(m));
        for (int k = 0; k < NF; k++)
            chk(offset[k*8 +: 8] == exp_off(m, vn, k), req, $sformatf("offset[%0d]", k),
                128'(offset[k*8 +: 8]), 128'(exp_off(m, vn, k)));
    endtask

    task automatic send_check(input logic [NF-1:0] m, input logic [16:0] v [NF], input string req);
        in_valid = 1'b1;
        fld = mk_bus(v);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1, req, "out_valid", 128'(out_valid), 128'(1));
        chk(128'(tuple) == exp_tuple(m, v), req, "tuple", 128'(tuple), exp_tuple(m, v));
    endtask

    task automatic t_reset;
        logic [16:0] z [NF];
        chk(present == '0, "R9", "present", 128'(present), 0);
        chk(offset == '1, "R9", "offsets", 128'(offset), {48'h0, 80'hFFFF_FFFF_FFFF_FFFF_FFFF});
        chk(cfg_err == 1'b0, "R9", "cfg_err", 128'(cfg_err), 0);
        chk(out_valid == 1'b0, "R9", "out_valid", 128'(out_valid), 0);
        chk(tuple == '0, "R9", "tuple", 128'(tuple), 0);
        send_check('0, pat_a, "R9");
        for (int k = 0; k < NF; k++) z[k] = '0;
        z[0] = 1'b0;
    endtask

    task automatic t_basic;
        logic [NF-1:0] m = 10'b10_0011_0010;
        load_cfg(m, 1'b1);
        check_cfg(m, 1'b1, "R1/R2");
        send_check(m, pat_a, "R4");
        send_check(m, pat_one, "R4");
        @(negedge clk);
        chk(out_valid == 1'b0, "R5", "valid drop", 128'(out_valid), 0);
    endtask

    task automatic t_vnic;
        logic [NF-1:0] m = 10'b00_0000_1100;
        load_cfg(m, 1'b1);
        check_cfg(m, 1'b1, "R1");
        load_cfg(m, 1'b0);
        check_cfg(m, 1'b0, "R3");
        send_check(m, pat_a, "R3");
    endtask

    task automatic t_settle;
        logic [NF-1:0] m = 10'b01_1000_0001;
        cfg_load = 1'b1;
        cfg_mask = m;
        cfg_vnic = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        chk(present == 10'b00_0000_1100, "R6", "present before commit", 128'(present), 128'(10'b00_0000_1100));
        in_valid = 1'b1;
        fld = mk_bus(pat_a);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b0, "R6", "settle out_valid", 128'(out_valid), 0);
        check_cfg(m, 1'b1, "R6");
        send_check(m, pat_a, "R6");
    endtask

    task automatic t_bound_err;
        logic [NF-1:0] m_ok = 10'b00_0100_1010;
        logic [NF-1:0] m_bad = 10'b00_0100_1011;
        load_cfg(m_ok, 1'b1);
        chk(cfg_err == 1'b0, "R8", "cfg_err", 128'(cfg_err), 0);
        send_check(m_ok, pat_one, "R8");
        chk(tuple[TMAX-1] == 1'b1, "R8", "top bit", 128'(tuple[TMAX-1]), 1);
        load_cfg(m_bad, 1'b1);
        chk(cfg_err == 1'b1, "R7", "cfg_err", 128'(cfg_err), 1);
        in_valid = 1'b1;
        fld = mk_bus(pat_a);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b0, "R7", "out_valid", 128'(out_valid), 0);
        load_cfg(10'b10_0011_0010, 1'b1);
        chk(cfg_err == 1'b0, "R10", "cfg_err", 128'(cfg_err), 0);
        send_check(10'b10_0011_0010, pat_a, "R10");
    endtask

    task automatic t_empty;
        load_cfg('0, 1'b1);
        check_cfg('0, 1'b1, "R2");
        send_check('0, pat_one, "R2");
    endtask

    initial begin
        for (int k = 0; k < NF; k++) pat_one[k] = 17'h1FFFF >> (17 - widths[k]);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_vnic();
        t_settle();
        t_bound_err();
        t_empty();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule